// File: doc/BRIEF.md
# Subcode Serial Capture Interface

This block pulls the six R–W subcode bits of each frame out of a CD signal processor over a three-wire serial link. The processor marks frames with a frame sync line and, in some host timing modes, a block sync line. The block watches the chosen frame sync edge. After a fixed confirmation delay it checks the sync line levels. If the frame is confirmed, it drives a burst of six shift clocks on its serial clock output and samples the data line once per clock.

Three host timing modes are selected by two static strap inputs. They differ in which frame sync edge starts a frame, in which levels confirm it, and in the idle polarity of the shift clock. The six captured bits are presented as a parallel symbol with a one-cycle valid strobe. A mute input silences the link completely. The confirmation delay and the shift clock half period are parameters counted in system clock cycles, so one netlist can serve any system clock rate.

Top module: `subcode_capture`

## Requirements
- R1: The mode is decoded from {mode_s1, mode_s2}. 2'b00 selects rising-edge mode A, 2'b10 selects falling-edge mode B, and 2'b11 selects inverted-clock mode C. The unused code 2'b01 behaves as mode A.
- R2: In mode B a falling edge of sfsy starts a frame. The burst starts only if sfsy is still low when the confirmation count expires. sbsy has no effect in this mode.
- R3: In modes A and C a rising edge of sfsy starts a frame. The burst starts only if, when the count expires, sfsy is high and sbsy is low. Otherwise no clock is sent.
- R4: On a confirmed frame, the first active sbck level appears on the (CONFIRM_CYC+3)-th rising clock edge after the sync change is presented.
- R5: A confirmed frame gives exactly SYM_BITS shift pulses. Each pulse is active for HALF_CYC cycles and then idle for HALF_CYC cycles.
- R6: pw is sampled as each pulse becomes active. The first bit (R) lands in sym_data[5] and the last bit (W) lands in sym_data[0].
- R7: In modes A and B, sbck idles low and pulses high. In mode C, sbck idles high and pulses low.
- R8: sym_valid is high for exactly one cycle, at the end of the sixth pulse period. sym_data changes only together with sym_valid and holds its value until the next strobe.
- R9: While mute is high, no pulse is issued, a running burst stops, no strobe is given, and pw and sbsy have no effect.
- R10: A start edge of the current mode that arrives during a burst aborts that burst with no strobe and begins a fresh confirmation.
- R11: During and after reset, sym_valid is low, sym_data is zero and the internal clock state is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfsy | input | 1 | Frame sync from the signal processor |
| sbsy | input | 1 | Block sync from the signal processor |
| pw | input | 1 | Serial subcode data |
| mute | input | 1 | High: link silenced |
| mode_s1 | input | 1 | Mode strap, upper bit |
| mode_s2 | input | 1 | Mode strap, lower bit |
| sbck | output | 1 | Shift clock to the signal processor |
| sym_data | output | SYM_BITS | Captured symbol, first bit in the MSB |
| sym_valid | output | 1 | One-cycle strobe for a new symbol |

## Verification
A phase counter that is off shows up as uneven sbck pulse widths within the first pulse of a frame. A wrong bit index shows up as five or seven pulses, and as a symbol rotated against the bits that were sent, at the strobe of that same frame. A controller stuck in its wait or burst state shows up as no sbck activity CONFIRM_CYC+3 cycles after a start edge, or as a missing or doubled strobe. Wrong confirmation logic shows up as a clock burst on frames that should be rejected. Every scenario is therefore judged within one frame time.

// File: rtl/subcode_pkg.sv
package subcode_pkg;

  typedef enum logic [1:0] {
    HM_RISE     = 2'd0,
    HM_FALL     = 2'd1,
    HM_RISE_INV = 2'd2
  } host_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_BURST   = 2'd2
  } cap_state_e;

  // R1: {s1,s2} = 10 -> falling mode, 11 -> inverted clock, else rising
  function automatic host_mode_e decode_mode(input logic s1, input logic s2);
    if (s1 && !s2)     return HM_FALL;
    else if (s1 && s2) return HM_RISE_INV;
    else               return HM_RISE;
  endfunction

endpackage

// File: rtl/subcode_in_stage.sv
module subcode_in_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic sfsy,
  input  logic sbsy,
  input  logic pw,
  output logic sfsy_lvl,
  output logic sbsy_lvl,
  output logic pw_lvl,
  output logic sfsy_rise,
  output logic sfsy_fall
);

  logic sfsy_q1, sfsy_q2, sbsy_q, pw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sfsy_q1 <= 1'b0;
      sfsy_q2 <= 1'b0;
      sbsy_q  <= 1'b0;
      pw_q    <= 1'b0;
    end else begin
      sfsy_q1 <= sfsy;
      sfsy_q2 <= sfsy_q1;
      sbsy_q  <= sbsy;
      pw_q    <= pw;
    end
  end

  assign sfsy_lvl  = sfsy_q1;
  assign sbsy_lvl  = sbsy_q;
  assign pw_lvl    = pw_q;
  assign sfsy_rise = sfsy_q1 & ~sfsy_q2;
  assign sfsy_fall = ~sfsy_q1 & sfsy_q2;

endmodule

// File: rtl/subcode_confirm_timer.sv
module subcode_confirm_timer #(
  parameter int unsigned CONFIRM_CYC = 275
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic expired
);

  localparam int unsigned CW = (CONFIRM_CYC > 1) ? $clog2(CONFIRM_CYC) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired = run && (cnt_q == CW'(CONFIRM_CYC - 1));
  assign cnt_en  = start | run;

  always_comb begin
    cnt_d = cnt_q;
    if (start)               cnt_d = '0;
    else if (run && !expired) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/subcode_shift_engine.sv
module subcode_shift_engine #(
  parameter int unsigned HALF_CYC = 32,
  parameter int unsigned SYM_BITS = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                abort,
  input  logic                pw_lvl,
  output logic                act,
  output logic                done,
  output logic [SYM_BITS-1:0] word
);

  localparam int unsigned PERIOD = 2 * HALF_CYC;
  localparam int unsigned PH_W   = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int unsigned IDX_W  = (SYM_BITS > 1) ? $clog2(SYM_BITS) : 1;

  logic                busy_q, busy_d;
  logic                act_q, act_d;
  logic [PH_W-1:0]     ph_q, ph_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [SYM_BITS-1:0] acc_q, acc_d;
  logic                ph_last, idx_last, eng_en;

  assign ph_last  = (ph_q == PH_W'(PERIOD - 1));
  assign idx_last = (idx_q == IDX_W'(SYM_BITS - 1));
  assign done     = busy_q && ph_last && idx_last;
  assign eng_en   = start | abort | busy_q;

  always_comb begin
    busy_d = busy_q;
    act_d  = act_q;
    ph_d   = ph_q;
    idx_d  = idx_q;
    acc_d  = acc_q;
    if (start) begin
      busy_d = 1'b1;
      act_d  = 1'b0;
      ph_d   = '0;
      idx_d  = '0;
    end else if (abort) begin
      busy_d = 1'b0;
      act_d  = 1'b0;
      ph_d   = '0;
      idx_d  = '0;
    end else if (busy_q) begin
      if (ph_q == '0) begin
        act_d = 1'b1;
        acc_d = {acc_q[SYM_BITS-2:0], pw_lvl};
      end else if (ph_q == PH_W'(HALF_CYC)) begin
        act_d = 1'b0;
      end
      if (ph_last) begin
        ph_d = '0;
        if (idx_last) busy_d = 1'b0;
        else          idx_d  = idx_q + 1'b1;
      end else begin
        ph_d = ph_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      act_q  <= 1'b0;
      ph_q   <= '0;
      idx_q  <= '0;
      acc_q  <= '0;
    end else if (eng_en) begin
      busy_q <= busy_d;
      act_q  <= act_d;
      ph_q   <= ph_d;
      idx_q  <= idx_d;
      acc_q  <= acc_d;
    end
  end

  assign act  = act_q;
  assign word = acc_q;

  AST_ACT_INSIDE_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> busy_q); // R5

endmodule

// File: rtl/subcode_capture.sv
module subcode_capture
  import subcode_pkg::*;
#(
  parameter int unsigned CONFIRM_CYC = 275,
  parameter int unsigned HALF_CYC    = 32,
  parameter int unsigned SYM_BITS    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sfsy,
  input  logic                sbsy,
  input  logic                pw,
  input  logic                mute,
  input  logic                mode_s1,
  input  logic                mode_s2,
  output logic                sbck,
  output logic [SYM_BITS-1:0] sym_data,
  output logic                sym_valid
);

  localparam int unsigned LC_W = $clog2(SYM_BITS + 1) + 1;

  logic sfsy_lvl, sbsy_lvl, pw_lvl, sfsy_rise, sfsy_fall;
  logic trig, conf_ok;
  logic tmr_start, tmr_run, tmr_expired;
  logic eng_start, eng_abort, eng_act, eng_done;
  logic [SYM_BITS-1:0] eng_word;
  logic valid_d;
  host_mode_e mode;
  cap_state_e state_q, state_d;
  logic [SYM_BITS-1:0] sym_q;
  logic                valid_q;

  subcode_in_stage u_in (
    .clk       (clk),
    .rst_n     (rst_n),
    .sfsy      (sfsy),
    .sbsy      (sbsy),
    .pw        (pw),
    .sfsy_lvl  (sfsy_lvl),
    .sbsy_lvl  (sbsy_lvl),
    .pw_lvl    (pw_lvl),
    .sfsy_rise (sfsy_rise),
    .sfsy_fall (sfsy_fall)
  );

  assign mode    = decode_mode(mode_s1, mode_s2);
  // R2/R3: start edge and confirmation levels per mode
  assign trig    = (mode == HM_FALL) ? sfsy_fall : sfsy_rise;
  assign conf_ok = (mode == HM_FALL) ? !sfsy_lvl : (sfsy_lvl && !sbsy_lvl);
  assign tmr_run = (state_q == ST_CONFIRM);

  subcode_confirm_timer #(.CONFIRM_CYC(CONFIRM_CYC)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tmr_start),
    .run     (tmr_run),
    .expired (tmr_expired)
  );

  subcode_shift_engine #(.HALF_CYC(HALF_CYC), .SYM_BITS(SYM_BITS)) u_eng (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (eng_start),
    .abort  (eng_abort),
    .pw_lvl (pw_lvl),
    .act    (eng_act),
    .done   (eng_done),
    .word   (eng_word)
  );

  always_comb begin
    state_d   = state_q;
    tmr_start = 1'b0;
    eng_start = 1'b0;
    eng_abort = 1'b0;
    valid_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (!mute && trig) begin
          state_d   = ST_CONFIRM;
          tmr_start = 1'b1;
        end
      end
      ST_CONFIRM: begin
        if (mute) begin
          state_d = ST_IDLE;
        end else if (trig) begin
          tmr_start = 1'b1;
        end else if (tmr_expired) begin
          if (conf_ok) begin
            state_d   = ST_BURST;
            eng_start = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_BURST: begin
        if (mute) begin
          state_d   = ST_IDLE;
          eng_abort = 1'b1;
        end else if (trig) begin
          state_d   = ST_CONFIRM;
          tmr_start = 1'b1;
          eng_abort = 1'b1;
        end else if (eng_done) begin
          state_d = ST_IDLE;
          valid_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sym_q <= '0;
    else if (valid_d) sym_q <= eng_word;
  end

  assign sym_data  = sym_q;
  assign sym_valid = valid_q;
  // R7: mode C inverts the idle level
  assign sbck      = eng_act ^ (mode == HM_RISE_INV);

  // Pulse tally used only by the assertions below
  logic            act_prev_q;
  logic [LC_W-1:0] lead_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_prev_q <= 1'b0;
      lead_cnt_q <= '0;
    end else begin
      act_prev_q <= eng_act;
      if (eng_start)                  lead_cnt_q <= '0;
      else if (eng_act && !act_prev_q) lead_cnt_q <= lead_cnt_q + 1'b1;
    end
  end

  AST_SIX_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> (lead_cnt_q == LC_W'(SYM_BITS))); // R5

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> !sym_valid); // R8

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |-> $stable(sym_data)); // R8

  AST_MUTE_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    mute |=> !eng_act); // R9

  AST_MUTE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mute) |-> !sym_valid); // R9

endmodule

// File: tb/subcode_capture_tb.sv
module subcode_capture_tb;

  localparam int C   = 8;
  localparam int H   = 2;
  localparam int WIN = 80;

  logic       clk;
  logic       rst_n;
  logic       sfsy, sbsy, pw, mute, s1, s2;
  logic       sbck;
  logic [5:0] sym_data;
  logic       sym_valid;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  int         r_pulses, r_first, r_valid, r_wbad;
  logic [5:0] r_got;
  logic       r_idle;

  subcode_capture #(.CONFIRM_CYC(C), .HALF_CYC(H), .SYM_BITS(6)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .sfsy      (sfsy),
    .sbsy      (sbsy),
    .pw        (pw),
    .mute      (mute),
    .mode_s1   (s1),
    .mode_s2   (s2),
    .sbck      (sbck),
    .sym_data  (sym_data),
    .sym_valid (sym_valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drives one frame and models the signal processor's data source.
  task automatic run_frame(input logic ms1, input logic ms2, input logic [5:0] bits,
                           input logic sb_lvl, input int hold, input int mute_at, input int rt);
    logic inv, trig_lvl, act, prev;
    int   idx, hi, base;
    inv      = ms1 & ms2;
    trig_lvl = !(ms1 && !ms2);
    @(negedge clk);
    mute = 1'b1; s1 = ms1; s2 = ms2; sfsy = !trig_lvl; sbsy = 1'b0; pw = 1'b0;
    repeat (4) @(negedge clk);
    mute = 1'b0;
    repeat (2) @(negedge clk);
    @(negedge clk);
    sfsy = trig_lvl; sbsy = sb_lvl; pw = bits[5];
    idx = 0; hi = 0; base = 0; prev = sbck ^ inv;
    r_pulses = 0; r_first = -1; r_valid = 0; r_wbad = 0; r_got = sym_data;
    for (int t = 1; t <= WIN; t++) begin
      @(negedge clk);
      if (t == hold)    sfsy = !trig_lvl;
      if (t == mute_at) mute = 1'b1;
      if (rt > 0 && t == rt)      sfsy = trig_lvl;
      if (rt > 0 && t == rt + 12) sfsy = !trig_lvl;
      if (rt > 0 && t == rt + 3) begin
        idx = 0; r_pulses = 0; r_first = -1; base = rt; pw = bits[5]; hi = 0;
      end
      act = sbck ^ inv;
      if (act && !prev) begin
        r_pulses++;
        if (r_first < 0) r_first = t - base;
      end
      if (act) hi++;
      if (!act && prev) begin
        if (hi != H) r_wbad++;
        hi = 0;
        idx++;
        if (idx < 6) pw = bits[5 - idx];
      end
      prev = act;
      if (sym_valid) begin
        r_valid++;
        r_got = sym_data;
      end
    end
    r_idle = sbck;
  endtask

  task automatic t_reset;
    chk("R11 valid low in reset", int'(sym_valid), 0);
    chk("R11 data zero in reset", int'(sym_data), 0);
    chk("R11 sbck idle in reset", int'(sbck), 0);
  endtask

  task automatic t_mode_a;
    run_frame(1'b0, 1'b0, 6'b101100, 1'b0, 15, -1, 0);
    chk("R5 mode A pulse count", r_pulses, 6);
    chk("R4 mode A first pulse delay", r_first, C + 3);
    chk("R5 mode A pulse width", r_wbad, 0);
    chk("R8 mode A one strobe", r_valid, 1);
    chk("R6 mode A symbol order", int'(r_got), 6'b101100);
    chk("R8 mode A symbol held", int'(sym_data), 6'b101100);
    chk("R7 mode A idles low", int'(r_idle), 0);
  endtask

  task automatic t_mode_c;
    run_frame(1'b1, 1'b1, 6'b010011, 1'b0, 15, -1, 0);
    chk("R3 mode C pulse count", r_pulses, 6);
    chk("R7 mode C idles high", int'(r_idle), 1);
    chk("R5 mode C pulse width", r_wbad, 0);
    chk("R6 mode C symbol", int'(r_got), 6'b010011);
  endtask

  task automatic t_mode_b;
    run_frame(1'b1, 1'b0, 6'b110001, 1'b1, 40, -1, 0);
    chk("R2 mode B accepted with sbsy high", r_pulses, 6);
    chk("R4 mode B first pulse delay", r_first, C + 3);
    chk("R6 mode B symbol", int'(r_got), 6'b110001);
    chk("R7 mode B idles low", int'(r_idle), 0);
  endtask

  task automatic t_reject_sbsy;
    run_frame(1'b0, 1'b0, 6'b111111, 1'b1, 15, -1, 0);
    chk("R3 sbsy high rejects: pulses", r_pulses, 0);
    chk("R3 sbsy high rejects: strobes", r_valid, 0);
  endtask

  task automatic t_reject_short_a;
    run_frame(1'b0, 1'b0, 6'b111111, 1'b0, 3, -1, 0);
    chk("R3 short sfsy rejects", r_pulses, 0);
    chk("R3 short sfsy data held", int'(sym_data), 6'b110001);
  endtask

  task automatic t_reject_short_b;
    run_frame(1'b1, 1'b0, 6'b000000, 1'b0, 3, -1, 0);
    chk("R2 short low sfsy rejects", r_pulses, 0);
  endtask

  task automatic t_mute_mid;
    run_frame(1'b0, 1'b0, 6'b000111, 1'b0, 15, 20, 0);
    chk("R9 mute stops burst", r_pulses, 3);
    chk("R9 mute gives no strobe", r_valid, 0);
    chk("R9 mute leaves data", int'(sym_data), 6'b110001);
    chk("R9 sbck idle after mute", int'(r_idle), 0);
  endtask

  task automatic t_mute_early;
    run_frame(1'b0, 1'b0, 6'b000000, 1'b0, 15, 1, 0);
    chk("R9 muted frame no pulses", r_pulses, 0);
    chk("R9 muted frame data unchanged", int'(sym_data), 6'b110001);
  endtask

  task automatic t_retrigger;
    run_frame(1'b0, 1'b0, 6'b011010, 1'b0, 12, -1, 20);
    chk("R10 single strobe after abort", r_valid, 1);
    chk("R10 fresh burst pulse count", r_pulses, 6);
    chk("R10 fresh burst delay", r_first, C + 3);
    chk("R10 symbol from fresh burst", int'(r_got), 6'b011010);
  endtask

  task automatic t_unused_code;
    run_frame(1'b0, 1'b1, 6'b100101, 1'b0, 15, -1, 0);
    chk("R1 code 01 acts as mode A", int'(r_got), 6'b100101);
    chk("R1 code 01 idles low", int'(r_idle), 0);
  endtask

  initial begin
    rst_n = 1'b0; sfsy = 1'b0; sbsy = 1'b0; pw = 1'b0; mute = 1'b1; s1 = 1'b0; s2 = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_mode_a();
    t_mode_c();
    t_mode_b();
    t_reject_sbsy();
    t_reject_short_a();
    t_reject_short_b();
    t_mute_mid();
    t_mute_early();
    t_retrigger();
    t_unused_code();
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule